// File: doc/BRIEF.md
# Context-Banked Floating-Point Register File

This block stores the working registers of a floating-point coprocessor: thirty-two 32-bit words, addressed 0 to 31, together with one control word and one status word. The low eight working registers and the control and status words exist once per interrupt priority level. A 3-bit priority input chooses which copy is live. Level 0 selects the base copy and levels 1 to 7 each select their own copy. The other twenty-four working registers form a single set that every level shares. When the level changes, the new copy is visible in the same cycle, and nothing is saved or restored.

The block has two read ports and one write port. Each port works on either one 32-bit word or one 64-bit value. A 64-bit value uses an even register as its low half and the next odd register as its high half. A read that falls in the same cycle as a write to the same word returns the data being written. The control and status words have their own write strobes and their own read outputs. The block is reachable only through these ports and is not mapped into memory. The surrounding instruction decode, the arithmetic units and any spilling of contexts to memory sit outside the block. The reset input is asynchronous, active low, and is expected to have been released synchronously upstream.

Top module: `fprf_banked_regfile`

## Requirements
- R1: After reset, every working register in every context reads zero. The control and status outputs read zero at every priority level.
- R2: A single-precision write (`wr_dbl`=0) stores `wr_data[31:0]` at `wr_idx`. A later single read of that index returns `{32'h0, word}`.
- R3: A double access (`*_dbl`=1) at an even index k places bits 31:0 in register k and bits 63:32 in register k+1. A double write updates both registers, and a double read returns `{reg[k+1], reg[k]}`.
- R4: A double access at an odd index is illegal. A read raises `rdN_illegal` and returns zero. A write raises `wr_illegal` and changes no register.
- R5: Registers 0 to 7 are held per context, and the context number equals `ipl`. A write made at one level cannot be seen at any other level.
- R6: Registers 8 to 31 are one set, and the same contents are visible at every level.
- R7: A change of `ipl` takes effect in the same cycle, with no extra cycles of delay.
- R8: When a read and a write address the same word in the same cycle, the read returns the data being written. Each half of a pair is bypassed on its own.
- R9: `ctl_wr_en` and `sts_wr_en` write the copy belonging to the active context. `ctl_rd_data` and `sts_rd_data` show the active copy, and a write becomes visible on the cycle after it. These words are not bypassed.
- R10: The two read ports work independently, each with its own index and width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ipl | input | 3 | Current interrupt priority level; selects the active context |
| wr_en | input | 1 | Write strobe for the working registers |
| wr_dbl | input | 1 | Write is a 64-bit pair |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data; bits 31:0 only when single |
| wr_illegal | output | 1 | Write is a double at an odd index |
| rd0_dbl | input | 1 | Port 0 reads a pair |
| rd0_idx | input | 5 | Port 0 register index |
| rd0_data | output | 64 | Port 0 data |
| rd0_illegal | output | 1 | Port 0 is a double at an odd index |
| rd1_dbl | input | 1 | Port 1 reads a pair |
| rd1_idx | input | 5 | Port 1 register index |
| rd1_data | output | 64 | Port 1 data |
| rd1_illegal | output | 1 | Port 1 is a double at an odd index |
| ctl_wr_en | input | 1 | Write the active control word |
| ctl_wr_data | input | 32 | Control write data |
| ctl_rd_data | output | 32 | Active control word |
| sts_wr_en | input | 1 | Write the active status word |
| sts_wr_data | input | 32 | Status write data |
| sts_rd_data | output | 32 | Active status word |

## Verification
The assertions check several properties on every cycle. A context whose level is not active holds its banked registers, control word and status word. The shared set changes only when a write hits its range. The two words of a double write are always adjacent. A single write followed by a read of the same index at the same level returns that word, and a control write appears on the next cycle. Other properties only the bench's sweeps can show: the zero state after reset, how data is placed across a pair, the zero data and unchanged registers for odd-index doubles, same-cycle bypass on both ports, and the split between banked and shared registers across all eight levels.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0]   word_t;
  typedef logic [2*WORD_W-1:0] dword_t;
endpackage

// File: rtl/fprf_wr_decode.sv
module fprf_wr_decode
  import fprf_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             wr_en,
  input  logic             wr_dbl,
  input  logic [IDX_W-1:0] wr_idx,
  input  dword_t           wr_data,
  output logic             lo_en,
  output logic [IDX_W-1:0] lo_idx,
  output word_t            lo_data,
  output logic             hi_en,
  output logic [IDX_W-1:0] hi_idx,
  output word_t            hi_data,
  output logic             illegal
);
  always_comb begin
    illegal = wr_en & wr_dbl & wr_idx[0];
    lo_en   = wr_en & ~illegal;
    hi_en   = wr_en & wr_dbl & ~wr_idx[0];
    lo_idx  = wr_idx;
    hi_idx  = wr_idx | IDX_W'(1);
    lo_data = wr_data[WORD_W-1:0];
    hi_data = wr_data[2*WORD_W-1:WORD_W];
  end

  always_comb begin
    if (hi_en) begin
      // R3
      pair_adjacent_chk: assert (lo_en && (hi_idx == lo_idx + IDX_W'(1)));
    end
  end
endmodule

// File: rtl/fprf_ctx_bank.sv
module fprf_ctx_bank
  import fprf_pkg::*;
#(
  parameter int NUM_BANKED = 8,
  parameter int NUM_CTX    = 8,
  parameter int IDX_W      = 5,
  parameter int CTX_W      = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CTX_W-1:0]                  ctx_sel,
  input  logic                              lo_en,
  input  logic [IDX_W-1:0]                  lo_idx,
  input  word_t                             lo_data,
  input  logic                              hi_en,
  input  logic [IDX_W-1:0]                  hi_idx,
  input  word_t                             hi_data,
  input  logic                              ctl_we,
  input  word_t                             ctl_wd,
  input  logic                              sts_we,
  input  word_t                             sts_wd,
  output logic [NUM_BANKED-1:0][WORD_W-1:0] act_regs,
  output word_t                             act_ctl,
  output word_t                             act_sts
);
  logic [NUM_BANKED-1:0][WORD_W-1:0] regs_q [NUM_CTX];
  logic [NUM_BANKED-1:0][WORD_W-1:0] regs_wd;
  logic [NUM_BANKED-1:0]             regs_we [NUM_CTX];
  word_t                             ctl_q   [NUM_CTX];
  word_t                             sts_q   [NUM_CTX];
  logic  [NUM_CTX-1:0]               ctx_hit;

  // next-state: per-word enables and data
  always_comb begin
    for (int w = 0; w < NUM_BANKED; w++) begin
      regs_wd[w] = (hi_en && hi_idx == IDX_W'(w)) ? hi_data : lo_data;
    end
    for (int c = 0; c < NUM_CTX; c++) begin
      ctx_hit[c] = (ctx_sel == CTX_W'(c));
      for (int w = 0; w < NUM_BANKED; w++) begin
        regs_we[c][w] = ctx_hit[c] &&
                        ((lo_en && lo_idx == IDX_W'(w)) || (hi_en && hi_idx == IDX_W'(w)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        regs_q[c] <= '0;
        ctl_q[c]  <= '0;
        sts_q[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CTX; c++) begin
        for (int w = 0; w < NUM_BANKED; w++) begin
          if (regs_we[c][w]) regs_q[c][w] <= regs_wd[w];
        end
        if (ctx_hit[c] && ctl_we) ctl_q[c] <= ctl_wd;
        if (ctx_hit[c] && sts_we) sts_q[c] <= sts_wd;
      end
    end
  end

  always_comb begin
    act_regs = regs_q[ctx_sel];
    act_ctl  = ctl_q[ctx_sel];
    act_sts  = sts_q[ctx_sel];
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx_chk
    // R5
    idle_ctx_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_sel != CTX_W'(c)) |=> $stable(regs_q[c]));
    // R9
    idle_ctx_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_sel != CTX_W'(c)) |=> ($stable(ctl_q[c]) && $stable(sts_q[c])));
  end
endmodule

// File: rtl/fprf_shared_bank.sv
module fprf_shared_bank
  import fprf_pkg::*;
#(
  parameter int NUM_SHARED = 24,
  parameter int BASE       = 8,
  parameter int IDX_W      = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              lo_en,
  input  logic [IDX_W-1:0]                  lo_idx,
  input  word_t                             lo_data,
  input  logic                              hi_en,
  input  logic [IDX_W-1:0]                  hi_idx,
  input  word_t                             hi_data,
  output logic [NUM_SHARED-1:0][WORD_W-1:0] regs
);
  logic [NUM_SHARED-1:0][WORD_W-1:0] regs_q;
  logic [NUM_SHARED-1:0][WORD_W-1:0] regs_wd;
  logic [NUM_SHARED-1:0]             regs_we;

  always_comb begin
    for (int w = 0; w < NUM_SHARED; w++) begin
      regs_we[w] = (lo_en && lo_idx == IDX_W'(BASE + w)) ||
                   (hi_en && hi_idx == IDX_W'(BASE + w));
      regs_wd[w] = (hi_en && hi_idx == IDX_W'(BASE + w)) ? hi_data : lo_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int w = 0; w < NUM_SHARED; w++) begin
        if (regs_we[w]) regs_q[w] <= regs_wd[w];
      end
    end
  end

  assign regs = regs_q;

  // R6
  shared_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lo_en && lo_idx >= IDX_W'(BASE)) && !(hi_en && hi_idx >= IDX_W'(BASE)))
    |=> $stable(regs_q));
endmodule

// File: rtl/fprf_rd_port.sv
module fprf_rd_port
  import fprf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5
) (
  input  logic [NUM_REGS-1:0][WORD_W-1:0] view,
  input  logic                            rd_dbl,
  input  logic [IDX_W-1:0]                rd_idx,
  input  logic                            lo_en,
  input  logic [IDX_W-1:0]                lo_idx,
  input  word_t                           lo_data,
  input  logic                            hi_en,
  input  logic [IDX_W-1:0]                hi_idx,
  input  word_t                           hi_data,
  output dword_t                          rd_data,
  output logic                            illegal
);
  logic [1:0][IDX_W-1:0] word_idx;
  word_t [1:0]           word_val;

  always_comb begin
    illegal     = rd_dbl & rd_idx[0];
    word_idx[0] = rd_idx;
    word_idx[1] = rd_idx | IDX_W'(1);
    for (int k = 0; k < 2; k++) begin
      if (hi_en && hi_idx == word_idx[k])      word_val[k] = hi_data;
      else if (lo_en && lo_idx == word_idx[k]) word_val[k] = lo_data;
      else                                     word_val[k] = view[word_idx[k]];
    end
    if (illegal)     rd_data = '0;
    else if (rd_dbl) rd_data = {word_val[1], word_val[0]};
    else             rd_data = {{WORD_W{1'b0}}, word_val[0]};
  end
endmodule

// File: rtl/fprf_banked_regfile.sv
module fprf_banked_regfile
  import fprf_pkg::*;
#(
  parameter  int NUM_REGS   = 32,
  parameter  int NUM_BANKED = 8,
  parameter  int NUM_CTX    = 8,
  localparam int IDX_W      = $clog2(NUM_REGS),
  localparam int CTX_W      = $clog2(NUM_CTX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CTX_W-1:0]    ipl,
  input  logic                wr_en,
  input  logic                wr_dbl,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [63:0]         wr_data,
  output logic                wr_illegal,
  input  logic                rd0_dbl,
  input  logic [IDX_W-1:0]    rd0_idx,
  output logic [63:0]         rd0_data,
  output logic                rd0_illegal,
  input  logic                rd1_dbl,
  input  logic [IDX_W-1:0]    rd1_idx,
  output logic [63:0]         rd1_data,
  output logic                rd1_illegal,
  input  logic                ctl_wr_en,
  input  logic [31:0]         ctl_wr_data,
  output logic [31:0]         ctl_rd_data,
  input  logic                sts_wr_en,
  input  logic [31:0]         sts_wr_data,
  output logic [31:0]         sts_rd_data
);
  localparam int NUM_SHARED = NUM_REGS - NUM_BANKED;
  localparam int NUM_RD     = 2;

  logic             lo_en, hi_en;
  logic [IDX_W-1:0] lo_idx, hi_idx;
  word_t            lo_data, hi_data;

  logic [NUM_BANKED-1:0][WORD_W-1:0] bank_view;
  logic [NUM_SHARED-1:0][WORD_W-1:0] shared_view;
  logic [NUM_REGS-1:0][WORD_W-1:0]   view;

  logic [NUM_RD-1:0]             rp_dbl, rp_ill;
  logic [NUM_RD-1:0][IDX_W-1:0]  rp_idx;
  dword_t [NUM_RD-1:0]           rp_data;

  fprf_wr_decode #(.IDX_W(IDX_W)) u_wdec (
    .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_idx(wr_idx), .wr_data(wr_data),
    .lo_en(lo_en), .lo_idx(lo_idx), .lo_data(lo_data),
    .hi_en(hi_en), .hi_idx(hi_idx), .hi_data(hi_data),
    .illegal(wr_illegal)
  );

  fprf_ctx_bank #(
    .NUM_BANKED(NUM_BANKED), .NUM_CTX(NUM_CTX), .IDX_W(IDX_W), .CTX_W(CTX_W)
  ) u_ctx (
    .clk(clk), .rst_n(rst_n), .ctx_sel(ipl),
    .lo_en(lo_en), .lo_idx(lo_idx), .lo_data(lo_data),
    .hi_en(hi_en), .hi_idx(hi_idx), .hi_data(hi_data),
    .ctl_we(ctl_wr_en), .ctl_wd(ctl_wr_data),
    .sts_we(sts_wr_en), .sts_wd(sts_wr_data),
    .act_regs(bank_view), .act_ctl(ctl_rd_data), .act_sts(sts_rd_data)
  );

  fprf_shared_bank #(
    .NUM_SHARED(NUM_SHARED), .BASE(NUM_BANKED), .IDX_W(IDX_W)
  ) u_shared (
    .clk(clk), .rst_n(rst_n),
    .lo_en(lo_en), .lo_idx(lo_idx), .lo_data(lo_data),
    .hi_en(hi_en), .hi_idx(hi_idx), .hi_data(hi_data),
    .regs(shared_view)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_view
    if (i < NUM_BANKED) begin : g_bank
      assign view[i] = bank_view[i];
    end else begin : g_shr
      assign view[i] = shared_view[i-NUM_BANKED];
    end
  end

  assign rp_dbl = {rd1_dbl, rd0_dbl};
  assign rp_idx = {rd1_idx, rd0_idx};

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    fprf_rd_port #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rp (
      .view(view), .rd_dbl(rp_dbl[p]), .rd_idx(rp_idx[p]),
      .lo_en(lo_en), .lo_idx(lo_idx), .lo_data(lo_data),
      .hi_en(hi_en), .hi_idx(hi_idx), .hi_data(hi_data),
      .rd_data(rp_data[p]), .illegal(rp_ill[p])
    );
  end

  assign rd0_data    = rp_data[0];
  assign rd1_data    = rp_data[1];
  assign rd0_illegal = rp_ill[0];
  assign rd1_illegal = rp_ill[1];

  // R2
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_dbl) ##1 (!wr_en && !rd0_dbl && rd0_idx == $past(wr_idx) && $stable(ipl))
    |-> rd0_data == {32'h0, $past(wr_data[31:0])});

  // R9
  ctl_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en ##1 $stable(ipl) |-> ctl_rd_data == $past(ctl_wr_data));

  // R4
  odd_pair_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dbl && wr_idx[0]) |-> wr_illegal);
endmodule

// File: tb/test_fprf_banked_regfile.sv
module test_fprf_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  ipl;
  logic        wr_en, wr_dbl;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;
  logic        wr_illegal;
  logic        rd0_dbl, rd1_dbl;
  logic [4:0]  rd0_idx, rd1_idx;
  logic [63:0] rd0_data, rd1_data;
  logic        rd0_illegal, rd1_illegal;
  logic        ctl_wr_en, sts_wr_en;
  logic [31:0] ctl_wr_data, sts_wr_data, ctl_rd_data, sts_rd_data;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mb [8][8];
  logic [31:0] ms [24];
  logic [31:0] mctl [8];
  logic [31:0] msts [8];

  always #4 clk = ~clk;

  fprf_banked_regfile i_fprf_banked_regfile (
    .clk(clk), .rst_n(rst_n), .ipl(ipl),
    .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_illegal(wr_illegal),
    .rd0_dbl(rd0_dbl), .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_dbl(rd1_dbl), .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data)
  );

  function automatic logic [31:0] mw(int p, int i);
    return (i < 8) ? mb[p][i] : ms[i-8];
  endfunction

  function automatic void mset(int p, int i, logic [31:0] v);
    if (i < 8) mb[p][i] = v;
    else       ms[i-8] = v;
  endfunction

  function automatic logic [31:0] pat(int p, int i, int s);
    return 32'hA000_0000 | 32'(p << 16) | 32'(i << 8) | 32'(s);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ipl = '0;
    wr_en = 0; wr_dbl = 0; wr_idx = '0; wr_data = '0;
    rd0_dbl = 0; rd1_dbl = 0; rd0_idx = '0; rd1_idx = '0;
    ctl_wr_en = 0; sts_wr_en = 0; ctl_wr_data = '0; sts_wr_data = '0;
    for (int p = 0; p < 8; p++) begin
      mctl[p] = '0; msts[p] = '0;
      for (int i = 0; i < 8; i++) mb[p][i] = '0;
    end
    for (int i = 0; i < 24; i++) ms[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: zero state at every level
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 32; i++) begin
        @(negedge clk); ipl = 3'(p); rd0_idx = 5'(i); rd1_idx = 5'(i & 30); rd1_dbl = 1;
        #2;
        chk("R1 single", rd0_data, 64'h0);
        chk("R1 double", rd1_data, 64'h0);
      end
      chk("R1 ctl", {32'h0, ctl_rd_data}, 64'h0);
      chk("R1 sts", {32'h0, sts_rd_data}, 64'h0);
    end

    // R8/R10: single write sweep with same-cycle bypass on port 0
    rd1_dbl = 0;
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        ipl = 3'(p); wr_en = 1; wr_dbl = 0; wr_idx = 5'(i);
        wr_data = {32'hDEAD_BEEF, pat(p, i, 1)};
        rd0_idx = 5'(i); rd1_idx = 5'(i ^ 1);
        #2;
        chk("R8 bypass single", rd0_data, {32'h0, pat(p, i, 1)});
        chk("R10 port1 other", rd1_data, {32'h0, mw(p, i ^ 1)});
        chk("R4 legal write flag", {63'h0, wr_illegal}, 64'h0);
        mset(p, i, pat(p, i, 1));
      end
    end
    @(negedge clk) wr_en = 0;

    // R2/R3/R5/R6: readback at every level
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        ipl = 3'(p); rd0_dbl = 0; rd0_idx = 5'(i); rd1_dbl = 1; rd1_idx = 5'(i & 30);
        #2;
        if (i < 8) chk("R5 banked readback", rd0_data, {32'h0, mw(p, i)});
        else       chk("R6 shared readback", rd0_data, {32'h0, mw(p, i)});
        chk("R3 pair read", rd1_data, {mw(p, i | 1), mw(p, i & 30)});
      end
    end

    // R3/R8: double writes with bypass on both halves
    for (int p = 0; p < 8; p += 3) begin
      for (int k = 0; k < 32; k += 2) begin
        @(negedge clk);
        ipl = 3'(p); wr_en = 1; wr_dbl = 1; wr_idx = 5'(k);
        wr_data = {pat(p, k + 1, 7), pat(p, k, 6)};
        rd0_dbl = 1; rd0_idx = 5'(k); rd1_dbl = 0; rd1_idx = 5'(k + 1);
        #2;
        chk("R8 bypass pair", rd0_data, {pat(p, k + 1, 7), pat(p, k, 6)});
        chk("R8 bypass high half", rd1_data, {32'h0, pat(p, k + 1, 7)});
        mset(p, k, pat(p, k, 6)); mset(p, k + 1, pat(p, k + 1, 7));
      end
    end
    @(negedge clk) wr_en = 0;
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 32; k += 2) begin
        @(negedge clk); ipl = 3'(p); rd0_dbl = 1; rd0_idx = 5'(k);
        #2;
        chk("R3 pair readback", rd0_data, {mw(p, k + 1), mw(p, k)});
      end
    end

    // R4: odd-index double write and read
    for (int k = 1; k < 32; k += 6) begin
      @(negedge clk);
      ipl = 3'd4; wr_en = 1; wr_dbl = 1; wr_idx = 5'(k); wr_data = 64'h1111_2222_3333_4444;
      rd0_dbl = 1; rd0_idx = 5'(k); rd1_dbl = 0; rd1_idx = 5'(k);
      #2;
      chk("R4 write flag", {63'h0, wr_illegal}, 64'h1);
      chk("R4 read flag", {63'h0, rd0_illegal}, 64'h1);
      chk("R4 read zero", rd0_data, 64'h0);
      chk("R4 no bypass", rd1_data, {32'h0, mw(4, k)});
      @(negedge clk);
      wr_en = 0; rd0_dbl = 0; rd0_idx = 5'(k - 1); rd1_idx = 5'(k);
      #2;
      chk("R4 low unchanged", rd0_data, {32'h0, mw(4, k - 1)});
      chk("R4 odd unchanged", rd1_data, {32'h0, mw(4, k)});
      rd1_idx = 5'((k + 1) & 31);
      #1;
      chk("R4 next unchanged", rd1_data, {32'h0, mw(4, (k + 1) & 31)});
    end

    // R7: level change seen within the same cycle
    @(negedge clk);
    rd0_dbl = 0; rd0_idx = 5'd3;
    for (int p = 0; p < 8; p++) begin
      ipl = 3'(7 - p);
      #0.5;
      chk("R7 immediate switch", rd0_data, {32'h0, mw(7 - p, 3)});
    end

    // R9: control/status per level, visible next cycle
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      ipl = 3'(p); ctl_wr_en = 1; sts_wr_en = 1;
      ctl_wr_data = pat(p, 0, 9); sts_wr_data = pat(p, 0, 10);
      #2;
      chk("R9 ctl not bypassed", {32'h0, ctl_rd_data}, {32'h0, mctl[p]});
      mctl[p] = pat(p, 0, 9); msts[p] = pat(p, 0, 10);
      @(negedge clk);
      ctl_wr_en = 0; sts_wr_en = 0;
      #2;
      chk("R9 ctl next cycle", {32'h0, ctl_rd_data}, {32'h0, mctl[p]});
    end
    for (int p = 0; p < 8; p++) begin
      @(negedge clk); ipl = 3'(p);
      #2;
      chk("R9 ctl per level", {32'h0, ctl_rd_data}, {32'h0, mctl[p]});
      chk("R9 sts per level", {32'h0, sts_rd_data}, {32'h0, msts[p]});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule